// File: doc/BRIEF.md
# Lock-Aware Bus Arbiter

This block shares one parallel bus among several masters and, separately from bus ownership, tracks one exclusive-access lock. Arbitration is round-robin. A new grant is issued only while the bus is idle, and it does not move while a transaction is in flight. Holding the grant gives a master no claim on the lock. A master takes the lock through its own handshake. It starts a downstream transaction with the lock input deasserted, then raises the lock input while that transaction runs. The block records the owning master and the 16-byte aligned region that transaction addressed.

While the lock is held, every transaction start gets a one-cycle verdict. A non-owner's downstream access to the locked region gets a retry pulse and does not occupy the bus. Every other transaction gets a forward pulse and proceeds: accesses outside the region, accesses travelling upstream, and the owner's own accesses. A mode input chooses between a resource lock and a complete bus lock. In the complete mode, only the lock owner may win arbitration, and the cache agent may also win while it signals a pending snoop writeback. Write posting is disabled for as long as the lock is held.

Top module: `lkarb_top`

## Requirements
- R1: When the bus is idle and no transaction starts, the grant moves to the first eligible requester after the last granted index (index 0 is searched first after reset). The grant is one-hot, or all zero when no eligible master requests. It appears one cycle after the request.
- R2: The grant stays unchanged from the cycle a transaction starts until the cycle after its end strobe.
- R3: A downstream transaction accepted while no lock is held, with the lock input low at its start, establishes the lock once the lock input is seen high while it runs. After that edge the held flag is 1 and the owner output gives that transaction's master index, whatever the grant does later.
- R4: A transaction that starts with the lock input already high, or an upstream transaction (direction input 0), never establishes a lock.
- R5: The lock releases on the edge where the owner's transaction ends with the lock input low. An end with the lock input high keeps the lock.
- R6: While the lock is held, a downstream start by a non-owner whose address bits above bit 3 equal those of the locked region produces retry high for exactly the following cycle. Forward stays low and the bus stays idle.
- R7: Every other accepted start produces forward high for exactly the following cycle, with retry low.
- R8: With complete-lock mode high and a lock held, only the owner is eligible, plus the cache master (parameter index, default 3) while its writeback input is high. With the mode low, all masters are eligible.
- R9: The posting-disable output is high exactly while the lock is held.
- R10: During and after reset, grant, retry, forward, held and posting-disable are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_MST | Per-master bus request |
| gnt_o | output | NUM_MST | Per-master one-hot grant |
| txn_start_i | input | 1 | One-cycle strobe: a transaction starts |
| txn_end_i | input | 1 | One-cycle strobe: the running transaction ends |
| txn_mst_i | input | IDW | Index of the master starting the transaction |
| txn_addr_i | input | ADDR_W | Transaction start address |
| txn_down_i | input | 1 | 1 = downstream (away from processor), 0 = upstream |
| lock_i | input | 1 | Lock signal, high = asserted |
| full_lock_i | input | 1 | 1 = complete-bus-lock mode, 0 = resource-lock mode |
| cache_wb_i | input | 1 | Cache master has a snoop writeback pending |
| retry_o | output | 1 | One-cycle retry verdict |
| fwd_o | output | 1 | One-cycle forward verdict |
| lock_held_o | output | 1 | A lock is currently held |
| lock_owner_o | output | IDW | Index of the lock owner |
| post_dis_o | output | 1 | Write posting disabled |

## Verification
The assertions assume a well-formed transaction stream. A start strobe comes only while the bus is idle, an end strobe only while a transaction runs, and never both in one cycle. The bench respects this: its start and end strobes are each one cycle wide, are separated by at least one cycle, and are driven on the falling edge. Arbitration vectors run only while the bus is idle. The writeback and mode inputs change only between transactions.

// File: rtl/lkarb_pkg.sv
package lkarb_pkg;
  // Lock granularity: address bits below this index are not compared.
  localparam int GRAN_BITS = 4;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_ARMED = 2'd1,
    LK_HELD  = 2'd2
  } lk_state_e;
endpackage

// File: rtl/lkarb_rst_sync.sv
module lkarb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/lkarb_rr.sv
module lkarb_rr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] elig_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IDW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]   gnt_q, gnt_d, cand;
  logic [IDW-1:0] last_q, last_d, pick;
  logic           found;

  assign cand = req_i & elig_i;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end

  always_comb begin
    gnt_d  = gnt_q;
    last_d = last_q;
    if (adv_i) begin
      gnt_d = found ? ({{(N-1){1'b0}}, 1'b1} << pick) : '0;
      if (found) last_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= IDW'(N - 1);
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign gnt_o = gnt_q;

  a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r1_gnt_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && (req_i == '0)) |=> (gnt_o == '0));
endmodule

// File: rtl/lkarb_lock.sv
module lkarb_lock
  import lkarb_pkg::*;
#(
  parameter int N      = 4,
  parameter int TAG_W  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [IDW-1:0]   mst_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             down_i,
  input  logic             lock_i,
  output logic             busy_o,
  output logic             retry_o,
  output logic             fwd_o,
  output logic             held_o,
  output logic [IDW-1:0]   owner_o
);
  localparam int IDW = (N > 1) ? $clog2(N) : 1;

  lk_state_e        st_q, st_d;
  logic             busy_q, busy_d, retry_q, fwd_q;
  logic [IDW-1:0]   cur_q, cur_d, own_q, own_d;
  logic [TAG_W-1:0] ctag_q, ctag_d, rtag_q, rtag_d;
  logic             hit, accept, reject;

  assign hit    = (st_q == LK_HELD) && down_i && (mst_i != own_q) && (tag_i == rtag_q);
  assign accept = start_i && !busy_q && !hit;
  assign reject = start_i && !busy_q && hit;

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    ctag_d = ctag_q;
    st_d   = st_q;
    own_d  = own_q;
    rtag_d = rtag_q;
    if (accept) begin
      busy_d = 1'b1;
      cur_d  = mst_i;
      ctag_d = tag_i;
    end else if (end_i && busy_q) begin
      busy_d = 1'b0;
    end
    unique case (st_q)
      LK_IDLE:  if (accept && down_i && !lock_i) st_d = LK_ARMED;
      LK_ARMED: begin
        if (busy_q && lock_i) begin
          st_d   = LK_HELD;
          own_d  = cur_q;
          rtag_d = ctag_q;
        end else if (end_i && busy_q) begin
          st_d = LK_IDLE;
        end
      end
      LK_HELD:  if (end_i && busy_q && (cur_q == own_q) && !lock_i) st_d = LK_IDLE;
      default:  st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      ctag_q  <= '0;
      own_q   <= '0;
      rtag_q  <= '0;
      retry_q <= 1'b0;
      fwd_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      ctag_q  <= ctag_d;
      own_q   <= own_d;
      rtag_q  <= rtag_d;
      retry_q <= reject;
      fwd_q   <= accept;
    end
  end

  assign busy_o  = busy_q;
  assign retry_o = retry_q;
  assign fwd_o   = fwd_q;
  assign held_o  = (st_q == LK_HELD);
  assign owner_o = own_q;

  a_r6_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_o && fwd_o));

  a_r6_retry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> ($past(start_i) && $past(held_o)));

  a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_o) |-> ($past(end_i) && !$past(lock_i)));

  a_r3_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && $past(held_o)) |-> $stable(owner_o));
endmodule

// File: rtl/lkarb_top.sv
module lkarb_top
  import lkarb_pkg::*;
#(
  parameter int NUM_MST  = 4,
  parameter int ADDR_W   = 32,
  parameter int CACHE_ID = 3,
  localparam int IDW     = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MST-1:0] req_i,
  output logic [NUM_MST-1:0] gnt_o,
  input  logic               txn_start_i,
  input  logic               txn_end_i,
  input  logic [IDW-1:0]     txn_mst_i,
  input  logic [ADDR_W-1:0]  txn_addr_i,
  input  logic               txn_down_i,
  input  logic               lock_i,
  input  logic               full_lock_i,
  input  logic               cache_wb_i,
  output logic               retry_o,
  output logic               fwd_o,
  output logic               lock_held_o,
  output logic [IDW-1:0]     lock_owner_o,
  output logic               post_dis_o
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic               srst_n, busy, held, adv;
  logic [IDW-1:0]     owner;
  logic [NUM_MST-1:0] elig;
  logic               unused_low_addr;

  assign unused_low_addr = ^txn_addr_i[GRAN_BITS-1:0];

  lkarb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (srst_n)
  );

  lkarb_lock #(.N(NUM_MST), .TAG_W(TAG_W)) u_lock (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (txn_start_i),
    .end_i   (txn_end_i),
    .mst_i   (txn_mst_i),
    .tag_i   (txn_addr_i[ADDR_W-1:GRAN_BITS]),
    .down_i  (txn_down_i),
    .lock_i  (lock_i),
    .busy_o  (busy),
    .retry_o (retry_o),
    .fwd_o   (fwd_o),
    .held_o  (held),
    .owner_o (owner)
  );

  for (genvar i = 0; i < NUM_MST; i++) begin : g_elig
    assign elig[i] = !(full_lock_i && held) || (owner == IDW'(i)) ||
                     ((i == CACHE_ID) && cache_wb_i);
  end

  assign adv = !busy && !txn_start_i;

  lkarb_rr #(.N(NUM_MST)) u_rr (
    .clk    (clk),
    .rst_n  (srst_n),
    .req_i  (req_i),
    .elig_i (elig),
    .adv_i  (adv),
    .gnt_o  (gnt_o)
  );

  assign lock_held_o  = held;
  assign lock_owner_o = owner;
  assign post_dis_o   = held;

  a_r2_gnt_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (busy || txn_start_i) |=> $stable(gnt_o));

  a_r8_full_excl: assert property (@(posedge clk) disable iff (!srst_n)
    (adv && held && full_lock_i && !cache_wb_i) |=>
      ((gnt_o & ~({{(NUM_MST-1){1'b0}}, 1'b1} << $past(owner))) == '0));

  a_r9_post_tracks_lock: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(post_dis_o) |-> ($past(lock_i) && $past(busy)));
endmodule

// File: tb/lkarb_top_tb.sv
module lkarb_top_tb;
  localparam int N   = 4;
  localparam int IDW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req, gnt;
  logic           start, fin, down, lk, full, wb;
  logic [IDW-1:0] mst;
  logic [31:0]    addr;
  logic           retry, fwd, held, pdis;
  logic [IDW-1:0] owner;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lkarb_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt),
    .txn_start_i(start), .txn_end_i(fin), .txn_mst_i(mst),
    .txn_addr_i(addr), .txn_down_i(down), .lock_i(lk),
    .full_lock_i(full), .cache_wb_i(wb), .retry_o(retry), .fwd_o(fwd),
    .lock_held_o(held), .lock_owner_o(owner), .post_dis_o(pdis)
  );

  // {req, expected grant}, applied back to back with the bus idle (R1)
  localparam logic [7:0] VEC [8] = '{
    8'b1111_0001, 8'b1111_0010, 8'b1001_1000, 8'b1001_0001,
    8'b0000_0000, 8'b0100_0100, 8'b0110_0010, 8'b0110_0100
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic begin_txn(input logic [IDW-1:0] m, input logic [31:0] a,
                           input logic d, input logic l);
    @(negedge clk);
    start = 1'b1; mst = m; addr = a; down = d; lk = l;
    tick();
  endtask

  task automatic end_txn(input logic l);
    @(negedge clk); start = 1'b0; fin = 1'b1; lk = l;
    tick();
    @(negedge clk); fin = 1'b0;
    tick();
  endtask

  task automatic set_req(input logic [N-1:0] r);
    @(negedge clk); req = r;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; req = '0; start = 0; fin = 0; mst = '0; addr = '0;
    down = 0; lk = 0; full = 0; wb = 0;
    repeat (3) tick();
    // R10: reset state
    chk("R10 gnt", gnt, 0);
    chk("R10 retry", retry, 0);
    chk("R10 fwd", fwd, 0);
    chk("R10 held", held, 0);
    chk("R10 pdis", pdis, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) tick();

    // R1: round-robin table
    for (int i = 0; i < 8; i++) begin
      set_req(VEC[i][7:4]);
      chk($sformatf("R1 vec%0d", i), gnt, VEC[i][3:0]);
    end
    set_req('0);

    // R4: lock already high at start does not lock
    begin_txn(0, 32'h100, 1, 1);
    chk("R7 fwd plain", fwd, 1);
    end_txn(1);
    chk("R4 lock-high start", held, 0);
    // R4: upstream does not lock
    begin_txn(0, 32'h100, 0, 0);
    @(negedge clk); start = 0; lk = 1; tick();
    end_txn(1);
    chk("R4 upstream", held, 0);
    @(negedge clk); lk = 0;

    // R2: grant held during transaction
    set_req(4'b0001);
    chk("R1 single", gnt, 4'b0001);
    begin_txn(0, 32'h200, 1, 1);
    @(negedge clk); start = 0; req = 4'b0010;
    tick(); tick();
    chk("R2 hold busy", gnt, 4'b0001);
    @(negedge clk); fin = 1'b1; tick();
    chk("R2 hold end edge", gnt, 4'b0001);
    @(negedge clk); fin = 1'b0; tick();
    chk("R2 move after end", gnt, 4'b0010);
    set_req('0);
    @(negedge clk); lk = 0;

    // R3: establish lock by master 1
    begin_txn(1, 32'h1000_0040, 1, 0);
    chk("R7 fwd establishing", fwd, 1);
    @(negedge clk); start = 0; lk = 1; tick();
    chk("R3 held", held, 1);
    chk("R3 owner", owner, 1);
    chk("R9 pdis on", pdis, 1);
    end_txn(1);
    chk("R5 keep with lock high", held, 1);

    // R6: non-owner to locked region, low bits differ
    begin_txn(2, 32'h1000_004C, 1, 1);
    chk("R6 retry", retry, 1);
    chk("R6 no fwd", fwd, 0);
    @(negedge clk); start = 0; tick();
    chk("R6 retry one cycle", retry, 0);
    set_req(4'b0100);
    chk("R6 bus idle, R8 resource mode grant", gnt, 4'b0100);
    set_req('0);

    // R7: other region, upstream, owner
    begin_txn(2, 32'h1000_0050, 1, 1);
    chk("R7 other region fwd", fwd, 1);
    chk("R7 other region retry", retry, 0);
    end_txn(1);
    begin_txn(2, 32'h1000_0040, 0, 1);
    chk("R7 upstream fwd", fwd, 1);
    end_txn(1);
    begin_txn(1, 32'h1000_0048, 1, 1);
    chk("R7 owner fwd", fwd, 1);
    end_txn(1);
    chk("R3 owner kept", owner, 1);

    // R8: complete-lock mode
    @(negedge clk); full = 1;
    set_req(4'b0100);
    chk("R8 non-owner blocked", gnt, 0);
    set_req(4'b0110);
    chk("R8 owner granted", gnt, 4'b0010);
    set_req(4'b1100);
    chk("R8 cache blocked w/o wb", gnt, 0);
    @(negedge clk); wb = 1; tick();
    chk("R8 cache wb granted", gnt, 4'b1000);
    @(negedge clk); wb = 0; req = '0; tick();

    // R5: release by owner
    begin_txn(1, 32'h2000_0000, 1, 1);
    @(negedge clk); start = 0; fin = 1; lk = 0; tick();
    chk("R5 released", held, 0);
    chk("R9 pdis off", pdis, 0);
    @(negedge clk); fin = 0; tick();
    set_req(4'b0100);
    chk("R8 full mode no lock", gnt, 4'b0100);
    set_req('0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule